// File: doc/BRIEF.md
# Multiplexed Row Scan Timing Generator

This block drives the row side of a time-multiplexed LED matrix. It runs from the PWM reference clock and splits time into row slots. Each slot starts with a blanking mask, in which the column drivers stay dark. Two PWM windows follow, and in these the column drivers show the grey-scale data of the active row. The block puts out a one-hot row select, the 0-based index of the row being shown, and phase strobes that the column block uses to read its memory row and to run its PWM compare.

There are two scan sources. In internal mode the block steps through the rows by itself, using either 8 rows or 16 rows. In external mode a 4-bit row address, synchronized into the clock domain, picks the row. A new slot starts every time that address changes. PWM windows then follow one after another for as long as the address holds.

A watchdog watches the row index. If the index does not change for a set number of cycles, the watchdog darkens all row outputs. The next row change turns them back on.

Top module: `row_scan_timer`

## Requirements
- R1: While `rst_n` is low, `row_sel` is all zero, `blank` is high and `row_idx` is 0.
- R2: A slot starts with `MASK_CYC` cycles of `mask_phase` high. Two windows of `PWM_CYC` cycles each follow, with `pwm_phase` high. `pwm_start` is high in the first cycle of each window. An internal slot therefore lasts `MASK_CYC + 2*PWM_CYC` cycles, which is 2109 with the defaults.
- R3: In internal mode with `rows16` low, `row_idx` steps 0,1,...,7,0 and advances once per slot. A frame is 8 slots.
- R4: In internal mode with `rows16` high, `row_idx` steps 0 to 15 and then wraps. A frame is 16 slots.
- R5: `row_sel` is either all zero or has only bit `row_idx` set. Bit k stands for row k+1, the row that shows memory row k (upper address nibble k).
- R6: In external mode, an address on `ext_row` that differs from `row_idx` appears on `row_idx` after the third rising clock edge. That slot starts in its mask phase. Address 0 selects bit 0 and address 15 selects bit 15.
- R7: In external mode, while the synchronized address stays equal to `row_idx`, PWM windows repeat back to back and no further mask phase appears.
- R8: If `row_idx` stays unchanged for `WDOG_CYC` consecutive cycles, `blank` goes high and `row_sel` goes to zero. They stay that way until the row changes.
- R9: In the cycle where `row_idx` takes a new value, the watchdog restarts. `blank` is low and the new row is driven.
- R10: If internal 8-row scanning starts with `row_idx` above 7, the slot end wraps the index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 = row chosen by `ext_row`, 0 = internal scan |
| rows16 | input | 1 | Internal scan length: 0 = 8 rows, 1 = 16 rows |
| ext_row | input | 4 | External row address, asynchronous |
| row_sel | output | 16 | One-hot row drive, bit k = row k+1 |
| row_idx | output | 4 | Memory row being displayed |
| mask_phase | output | 1 | Blanking mask of the slot |
| pwm_phase | output | 1 | A PWM window is in progress |
| pwm_start | output | 1 | First cycle of a PWM window |
| blank | output | 1 | Display forced dark, by reset or by the watchdog |

## Verification
The hardest states to reach are the watchdog timeout and its recovery. Internal scanning changes rows every slot, so the timeout can only fire in external mode with the address held. The bench shortens the slot and timeout lengths through parameters. It holds one address for longer than the timeout, then steps to a new address and checks that the outputs come back after the synchronizer delay. It also leaves row 12 selected from external mode and then switches to 8-row internal scanning, to reach the out-of-range wrap.

// File: rtl/row_scan_timer.sv
module row_scan_timer #(
  parameter int MASK_CYC = 63,
  parameter int PWM_CYC  = 1023,
  parameter int WDOG_CYC = 3_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_mode,
  input  logic        rows16,
  input  logic [3:0]  ext_row,
  output logic [15:0] row_sel,
  output logic [3:0]  row_idx,
  output logic        mask_phase,
  output logic        pwm_phase,
  output logic        pwm_start,
  output logic        blank
);
  localparam int CNT_W = $clog2(MASK_CYC + PWM_CYC + 1);
  localparam int WD_W  = $clog2(WDOG_CYC + 1);
  localparam logic [CNT_W-1:0] MASK_LAST = CNT_W'(MASK_CYC - 1);
  localparam logic [CNT_W-1:0] PWM_LAST  = CNT_W'(PWM_CYC - 1);
  localparam logic [WD_W-1:0]  WD_LIMIT  = WD_W'(WDOG_CYC);

  logic [3:0]       sync1, sync2, row_nxt, last_row;
  logic [CNT_W-1:0] cnt;
  logic [WD_W-1:0]  wd_cnt;
  logic             in_pwm, second, live;
  logic             ext_jump, win_end, slot_end, timeout;

  assign last_row = rows16 ? 4'd15 : 4'd7;
  assign ext_jump = ext_mode && (sync2 != row_idx);
  assign win_end  = in_pwm && (cnt == PWM_LAST);
  assign slot_end = !ext_mode && win_end && second;
  assign timeout  = (wd_cnt == WD_LIMIT);

  always_comb begin
    row_nxt = row_idx;
    if (ext_jump)
      row_nxt = sync2;
    else if (slot_end)
      row_nxt = (row_idx >= last_row) ? 4'd0 : row_idx + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      row_idx <= '0;
      cnt     <= '0;
      in_pwm  <= 1'b0;
      second  <= 1'b0;
      live    <= 1'b0;
      wd_cnt  <= '0;
    end else begin
      sync1   <= ext_row;
      sync2   <= sync1;
      live    <= 1'b1;
      row_idx <= row_nxt;
      if (ext_jump || slot_end) begin
        in_pwm <= 1'b0;
        cnt    <= '0;
        second <= 1'b0;
      end else if (!in_pwm) begin
        if (cnt == MASK_LAST) begin
          in_pwm <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (win_end) begin
        cnt    <= '0;
        second <= ~second;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (row_nxt != row_idx)
        wd_cnt <= '0;
      else if (!timeout)
        wd_cnt <= wd_cnt + 1'b1;
    end
  end

  assign blank      = !live || timeout;
  assign row_sel    = blank ? 16'd0 : (16'd1 << row_idx);
  assign mask_phase = !in_pwm;
  assign pwm_phase  = in_pwm;
  assign pwm_start  = in_pwm && (cnt == '0);
endmodule

// File: rtl/row_scan_timer_chk.sv
module row_scan_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_mode,
  input logic [15:0] row_sel,
  input logic [3:0]  row_idx,
  input logic        mask_phase,
  input logic        pwm_phase,
  input logic        pwm_start,
  input logic        blank
);
  // R1
  reset_dark_chk: assert property (@(posedge clk) !rst_n |-> (row_sel == 16'd0 && blank));
  // R2
  mask_to_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mask_phase) |-> pwm_start);
  // R2
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_phase) |-> pwm_start);
  // R3
  advance_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && $past(!ext_mode) && row_idx != $past(row_idx)) |-> (mask_phase && $past(pwm_phase)));
  // R5
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(row_sel));
  // R5
  sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n) !blank |-> row_sel[row_idx]);
  // R8
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n) blank |-> row_sel == 16'd0);
  // R9
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_idx != $past(row_idx)) |-> !blank);
endmodule

bind row_scan_timer row_scan_timer_chk u_chk (.*);

// File: tb/row_scan_timer_test.sv
`timescale 1ns/1ps
module row_scan_timer_test;
  localparam int MASK = 5, PWM = 12, WDOG = 200, SLOT = MASK + 2*PWM;

  logic clk = 0, rst_n = 0, ext_mode = 0, rows16 = 0;
  logic [3:0] ext_row = 0;
  logic [15:0] row_sel;
  logic [3:0] row_idx;
  logic mask_phase, pwm_phase, pwm_start, blank;
  int tests = 0, fails = 0, cycles = 0;

  row_scan_timer #(.MASK_CYC(MASK), .PWM_CYC(PWM), .WDOG_CYC(WDOG)) uut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .rows16(rows16), .ext_row(ext_row),
    .row_sel(row_sel), .row_idx(row_idx), .mask_phase(mask_phase), .pwm_phase(pwm_phase),
    .pwm_start(pwm_start), .blank(blank));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      if (fails < 20) $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference
  int m_row, m_pos, m_wd, s1, s2;
  bit m_live;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_row = 0; m_pos = 0; m_wd = 0; s1 = 0; s2 = 0; m_live = 0;
    end else begin
      int nr, lastr;
      nr = m_row;
      lastr = rows16 ? 15 : 7;
      if (ext_mode && s2 != m_row) begin
        nr = s2; m_pos = 0;
      end else begin
        m_pos++;
        if (m_pos == SLOT) begin
          if (!ext_mode) begin
            m_pos = 0;
            nr = (m_row >= lastr) ? 0 : m_row + 1;
          end else m_pos = MASK;
        end
      end
      if (nr != m_row) m_wd = 0;
      else if (m_wd < WDOG) m_wd++;
      m_row = nr;
      s2 = s1; s1 = ext_row;
      m_live = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      bit dark;
      dark = (m_wd == WDOG);
      chk(ext_mode ? "R6 row_idx" : (rows16 ? "R4 row_idx" : "R3 row_idx"), row_idx, m_row);
      chk("R5 row_sel", row_sel, dark ? 0 : (32'd1 << m_row));
      chk("R8 blank", blank, dark);
      chk("R2 mask_phase", mask_phase, m_pos < MASK);
      chk("R2 pwm_phase", pwm_phase, m_pos >= MASK);
      chk("R2 pwm_start", pwm_start, (m_pos >= MASK) && ((m_pos - MASK) % PWM == 0));
    end
  end

  task automatic next_change(output int n);
    logic [3:0] start;
    start = row_idx;
    n = 0;
    do begin @(negedge clk); n++; end while (row_idx == start && n < 1000);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, mx;
    logic [3:0] r0;
    repeat (3) @(negedge clk);
    chk("R1 reset row_sel", row_sel, 0);
    chk("R1 reset blank", blank, 1);
    chk("R1 reset row_idx", row_idx, 0);
    rst_n = 1;

    next_change(n);
    chk("R2 first slot length", n, SLOT);
    next_change(n);
    chk("R2 slot length", n, SLOT);

    r0 = row_idx; mx = 0;
    for (int i = 0; i < 8; i++) begin
      next_change(n);
      if (row_idx > mx) mx = row_idx;
    end
    chk("R3 frame returns", row_idx, r0);
    chk("R3 max row", mx, 7);

    rows16 = 1;
    next_change(n);
    r0 = row_idx; mx = 0;
    for (int i = 0; i < 16; i++) begin
      next_change(n);
      if (row_idx > mx) mx = row_idx;
    end
    chk("R4 frame returns", row_idx, r0);
    chk("R4 max row", mx, 15);

    ext_mode = 1; ext_row = 4'd9;
    repeat (3) @(negedge clk);
    chk("R6 ext row", row_idx, 9);
    chk("R6 slot restarts in mask", mask_phase, 1);
    chk("R6 decode", row_sel, 16'h0200);
    repeat (MASK + 2) @(negedge clk);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mask_phase) n++;
    end
    chk("R7 no mask while held", n, 0);
    repeat (WDOG) @(negedge clk);
    chk("R8 timeout blank", blank, 1);
    chk("R8 timeout rows off", row_sel, 0);

    ext_row = 4'd2;
    repeat (3) @(negedge clk);
    chk("R9 restored blank", blank, 0);
    chk("R9 restored row", row_sel, 16'h0004);

    ext_row = 4'd15;
    repeat (3) @(negedge clk);
    chk("R6 address 15", row_sel, 16'h8000);
    ext_row = 4'd0;
    repeat (3) @(negedge clk);
    chk("R6 address 0", row_sel, 16'h0001);

    for (int i = 0; i < 10; i++) begin
      ext_row = 4'(i * 7);
      @(negedge clk);
    end

    ext_row = 4'd12;
    repeat (6) @(negedge clk);
    chk("R10 parked row", row_idx, 12);
    ext_mode = 0; rows16 = 0;
    next_change(n);
    chk("R10 wrap to 0", row_idx, 0);
    repeat (50) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule